// File: doc/BRIEF.md
# Bit-Error-Rate Tester Status Flags

This block gathers the status of a bit error rate tester into a single byte that software reads through a small address/read-strobe bus. The receive side provides its live conditions: whether the pattern synchroniser is locked, a pulse when the bit counter or the error counter wraps, and a level showing that the error count is non-zero. The block also watches the received serial stream itself. In pseudorandom mode it reports a run of 40 identical bits, either all ones or all zeros.

Flags follow one of three disciplines. The lock state is shown live. The three counter events are held until a read clears them. The loss-of-lock flag and the two run flags are also held, but a read clears them only when the condition behind them has gone away. A read of the status address clears the held flags on the clock edge that ends the read cycle. A condition present in that same cycle keeps its flag set, so no event is lost.

Top module: `bert_status_reg`

## Requirements
- R1: Read data is combinational. While `rd_en_i` is high and `addr_i` equals STATUS_ADDR (default 4), `rd_data_o` returns {bit7 = 0, bit6 all-ones run, bit5 all-zeros run, bit4 error detected, bit3 error-counter overflow, bit2 bit-counter overflow, bit1 loss of sync, bit0 in sync}. In every other cycle it is 8'h00. A strobe to any other address clears nothing.
- R2: Bit 0 follows `sync_i` in the same cycle and is never latched.
- R3: Bits 2 and 3 are set on the clock edge after a pulse on `bit_cnt_ovf_i` or `err_cnt_ovf_i`. They hold until an addressed read, which clears them on its closing edge.
- R4: If a flag's event or condition is present in the cycle of an addressed read, the flag is still set after that edge.
- R5: Bit 4 is set on each edge where `err_nonzero_i` is high. After a read it sets again while the input stays high.
- R6: Bits 1, 5 and 6 are held. A read clears them only if their condition is absent in the read cycle.
- R7: The loss-of-sync condition (bit 1) is `sync_i` low.
- R8: The all-ones condition (bit 6) holds once 40 consecutive ones have been received with `rx_valid_i` high and `prbs_mode_i` high. The run count saturates at 40. A valid zero resets it. Cycles with `rx_valid_i` low neither count nor reset.
- R9: The all-zeros condition (bit 5) is the mirror of R8: 40 valid zeros set it, and a valid one resets the count.
- R10: While `prbs_mode_i` is low, both run counts are held at zero and no run condition arises.
- R11: While `rst_n` is low, all held flags and run counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Synchroniser locked (live) |
| bit_cnt_ovf_i | input | 1 | Bit counter wrapped (one-cycle pulse) |
| err_cnt_ovf_i | input | 1 | Error counter wrapped (one-cycle pulse) |
| err_nonzero_i | input | 1 | Error count is non-zero (level) |
| prbs_mode_i | input | 1 | Receiver runs in pseudorandom mode |
| rx_valid_i | input | 1 | Received bit strobe |
| rx_bit_i | input | 1 | Received bit value |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data |

## Verification
The hardest case to reach from the ports is a held run flag at the exact 40-bit boundary. A run must be precisely 39 or 40 valid bits long, with invalid gaps inside it that must not break the count. A read must then land while the run still persists, and again after one opposite bit has ended it. Purely random bits almost never form such runs. The stimulus therefore holds a chosen bit value for a random length of up to 60 valid bits, and adds directed sequences of 39 bits, 40 bits, and a gapped run. Reads that coincide with counter pulses and with a live loss of lock are also driven on purpose.

// File: rtl/bert_status_pkg.sv
package bert_status_pkg;
  localparam int NFLAG = 6;
  // held-flag indices; status byte bit = index + 1
  localparam int F_LOS  = 0;
  localparam int F_BOV  = 1;
  localparam int F_EOV  = 2;
  localparam int F_ERR  = 3;
  localparam int F_ZRUN = 4;
  localparam int F_ORUN = 5;

  function automatic logic flag_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic int run_next(input int cnt, input int limit, input logic valid,
                                  input logic mode, input logic match);
    if (!mode) return 0;
    if (!valid) return cnt;
    if (!match) return 0;
    return (cnt >= limit) ? limit : cnt + 1;
  endfunction
endpackage

// File: rtl/bert_run_detector.sv
module bert_run_detector #(
  parameter int  RUN_LEN = 40,
  parameter logic MATCH  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic valid_i,
  input  logic bit_i,
  output logic hit_o
);
  import bert_status_pkg::*;
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          bit_match;

  assign bit_match = (bit_i == MATCH);
  assign cnt_d = CW'(run_next(int'(cnt_q), RUN_LEN, valid_i, mode_i, bit_match));
  assign hit_o = (cnt_q == CW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_run_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(RUN_LEN));
  assert_run_reset_on_opposite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && valid_i && bit_i != MATCH) |=> (cnt_q == '0));
  assert_run_holds_without_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && !valid_i) |=> $stable(cnt_q));
  assert_run_idle_out_of_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> (cnt_q == '0 && !hit_o));
endmodule

// File: rtl/bert_flag_cell.sv
module bert_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import bert_status_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= flag_next(q_o, set_i, clr_i);
  end

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // also R6
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/bert_status_reg.sv
module bert_status_reg #(
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 4,
  parameter int RUN_LEN     = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              bit_cnt_ovf_i,
  input  logic              err_cnt_ovf_i,
  input  logic              err_nonzero_i,
  input  logic              prbs_mode_i,
  input  logic              rx_valid_i,
  input  logic              rx_bit_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        rd_data_o
);
  import bert_status_pkg::*;

  logic             rd_hit;
  logic             ones_hit;
  logic             zeros_hit;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;
  logic [7:0]       status;

  assign rd_hit = rd_en_i && (addr_i == ADDR_W'(STATUS_ADDR));

  bert_run_detector #(.RUN_LEN(RUN_LEN), .MATCH(1'b1)) u_ones (
    .clk(clk), .rst_n(rst_n), .mode_i(prbs_mode_i), .valid_i(rx_valid_i),
    .bit_i(rx_bit_i), .hit_o(ones_hit));

  bert_run_detector #(.RUN_LEN(RUN_LEN), .MATCH(1'b0)) u_zeros (
    .clk(clk), .rst_n(rst_n), .mode_i(prbs_mode_i), .valid_i(rx_valid_i),
    .bit_i(rx_bit_i), .hit_o(zeros_hit));

  always_comb begin
    flag_set         = '0;
    flag_set[F_LOS]  = ~sync_i;
    flag_set[F_BOV]  = bit_cnt_ovf_i;
    flag_set[F_EOV]  = err_cnt_ovf_i;
    flag_set[F_ERR]  = err_nonzero_i;
    flag_set[F_ZRUN] = zeros_hit;
    flag_set[F_ORUN] = ones_hit;
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    bert_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set[k]), .clr_i(rd_hit), .q_o(flag_q[k]));
  end

  assign status    = {1'b0, flag_q, sync_i};
  assign rd_data_o = rd_hit ? status : 8'h00;

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data_o == 8'h00));
  assert_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[7] == 1'b0);
  assert_lost_sync_latches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> flag_q[F_LOS]);
  assert_ones_run_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> flag_q[F_ORUN]);
  assert_runs_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ones_hit, zeros_hit}));
endmodule

// File: tb/sim_bert_status_reg.sv
module sim_bert_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_i = 1'b1, bov = 1'b0, eov = 1'b0, enz = 1'b0;
  logic       mode = 1'b1, valid = 1'b0, rbit = 1'b0, rd = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] rdata;

  int checks = 0, failures = 0;
  int c1 = 0, c0 = 0;
  logic [5:0] mf = '0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  bert_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_cnt_ovf_i(bov),
    .err_cnt_ovf_i(eov), .err_nonzero_i(enz), .prbs_mode_i(mode),
    .rx_valid_i(valid), .rx_bit_i(rbit), .rd_en_i(rd), .addr_i(addr),
    .rd_data_o(rdata));

  function automatic string bit_tag(input int b);
    case (b)
      0: return "R2";
      1: return "R7";
      2, 3: return "R3";
      4: return "R5";
      5: return "R9";
      6: return "R8";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [7:0] model_read();
    if (rd && addr == 4'd4) return {1'b0, mf, sync_i};
    return 8'h00;
  endfunction

  function automatic int sat_step(input int c, input logic same);
    if (!mode) return 0;
    if (!valid) return c;
    if (!same) return 0;
    return (c < 40) ? c + 1 : 40;
  endfunction

  task automatic chk(input logic [7:0] g, input logic [7:0] e, input string tag);
    checks++;
    if (g !== e) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, g, e);
    end
  endtask

  // drive one cycle; inputs already set; compare read, advance model
  task automatic tick(output logic [7:0] g);
    logic [7:0] e;
    logic [5:0] setv;
    #1;
    g = rdata;
    if (rd) begin
      e = model_read();
      checks++;
      if (g !== e) begin
        failures++;
        for (int b = 0; b < 8; b++)
          if (g[b] !== e[b])
            $display("FAIL %s: bit%0d got %h expected %h", bit_tag(b), b, g, e);
      end
    end
    @(posedge clk);
    setv = {c1 == 40, c0 == 40, enz, eov, bov, ~sync_i};
    mf = setv | (mf & ~{6{rd && addr == 4'd4}});
    c1 = sat_step(c1, rbit == 1'b1);
    c0 = sat_step(c0, rbit == 1'b0);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    logic [7:0] g;
    for (int i = 0; i < n; i++) begin
      rd = 0; bov = 0; eov = 0; valid = 0;
      tick(g);
    end
  endtask

  task automatic rd_status(input logic [3:0] a, output logic [7:0] g);
    rd = 1; addr = a; valid = 0; bov = 0; eov = 0;
    tick(g);
    rd = 0;
  endtask

  task automatic send(input logic v, input int n);
    logic [7:0] g;
    for (int i = 0; i < n; i++) begin
      rd = 0; valid = 1; rbit = v;
      tick(g);
    end
    valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    sync_i = 0; rd = 1; addr = 4'd4;
    repeat (3) @(negedge clk);
    #1 chk(rdata, 8'h00, "R11 reset state");
    rd = 0; sync_i = 1;
    @(negedge clk);
    rst_n = 1;

    // R7 / R6: loss of sync held while condition present
    sync_i = 0; idle(3);
    rd_status(4'd4, got); chk(got, 8'h02, "R7 lost sync read");
    sync_i = 1; idle(1);
    rd_status(4'd4, got); chk(got, 8'h03, "R6 held after sync back");
    rd_status(4'd4, got); chk(got, 8'h01, "R6 cleared once ended");

    // R3: counter event held then cleared
    bov = 1; idle(0); rd = 0; begin logic [7:0] g; tick(g); end
    bov = 0; idle(1);
    rd_status(4'd4, got); chk(got, 8'h05, "R3 bit-counter overflow");
    rd_status(4'd4, got); chk(got, 8'h01, "R3 clear on read");

    // R4: event in same cycle as read
    rd = 1; addr = 4'd4; eov = 1; begin logic [7:0] g; tick(g); chk(g, 8'h01, "R4 read before edge"); end
    eov = 0; rd = 0;
    rd_status(4'd4, got); chk(got, 8'h09, "R4 event survives read");
    rd_status(4'd4, got); chk(got, 8'h01, "R4 cleared afterwards");

    // R5: error-detected follows level
    enz = 1; idle(1);
    rd_status(4'd4, got); chk(got, 8'h11, "R5 error detected");
    enz = 0;
    rd_status(4'd4, got); chk(got, 8'h11, "R5 re-set while nonzero");
    rd_status(4'd4, got); chk(got, 8'h01, "R5 cleared after level drop");

    // R8: 39 ones is not enough, 40 is
    mode = 1;
    send(1, 39); send(0, 1); idle(1);
    rd_status(4'd4, got); chk(got, 8'h01, "R8 39 ones no run");
    send(1, 40); idle(1);
    rd_status(4'd4, got); chk(got, 8'h41, "R8 40 ones run");
    rd_status(4'd4, got); chk(got, 8'h41, "R6 run persists over read");
    send(0, 1);
    rd_status(4'd4, got); chk(got, 8'h41, "R8 held after zero");
    rd_status(4'd4, got); chk(got, 8'h01, "R8 cleared after zero");
    // invalid gaps do not break a run
    send(1, 20); rbit = 0; idle(5); send(1, 20); idle(1);
    rd_status(4'd4, got); chk(got, 8'h41, "R8 gaps ignored");
    send(0, 1); rd_status(4'd4, got); rd_status(4'd4, got);
    chk(got, 8'h01, "R8 run ended");

    // R9: all zeros
    send(0, 40); idle(1);
    rd_status(4'd4, got); chk(got, 8'h21, "R9 40 zeros run");

    // R10: out of pseudorandom mode
    mode = 0; send(1, 50); idle(1);
    rd_status(4'd4, got); chk(got, 8'h21, "R10 leftover zeros flag");
    rd_status(4'd4, got); chk(got, 8'h01, "R10 no run out of mode");
    mode = 1;

    // R1: other address returns zero and clears nothing
    bov = 1; begin logic [7:0] g; tick(g); end
    bov = 0;
    rd_status(4'd5, got); chk(got, 8'h00, "R1 other address");
    rd_status(4'd4, got); chk(got, 8'h05, "R1 flag kept");

    // random phase against the bench model
    begin
      int hold = 0;
      logic v = 0;
      for (int i = 0; i < 6000; i++) begin
        if (hold == 0) begin hold = 1 + ($urandom % 60); v = $urandom % 2; end
        valid = ($urandom % 10) < 8;
        rbit  = v;
        if (valid) hold--;
        mode  = ($urandom % 50) != 0;
        bov   = ($urandom % 40) == 0;
        eov   = ($urandom % 40) == 0;
        if (($urandom % 30) == 0) enz = ~enz;
        if (($urandom % 60) == 0) sync_i = ~sync_i;
        rd    = ($urandom % 5) == 0;
        addr  = (($urandom % 6) == 0) ? 4'($urandom) : 4'd4;
        tick(got);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule